// File: doc/BRIEF.md
# Wake Interrupt Sense Normaliser

This block is a bank of per-line front ends placed between asynchronous wake sources and an interrupt controller that accepts only active-high levels and rising edges. Each line carries a 3-bit sense code and an enable bit. Both are held in a small register file reached through a word-addressed register bus.

Each line first passes its input through a two-flop synchroniser. The sense code then chooses one of two treatments:

- Level codes pass the synchronised input through to the output, inverted where the line is active-low.
- Edge codes turn every qualifying transition into a single-cycle high pulse. Qualifying transitions are the rise, the fall, or both.

The enable bit gates the result, and the output is registered. Software configures each line and then changes enables by read-modify-write of the packed enable words.

Top module: `wake_sense_norm`

## Requirements
- R1: After reset every enable bit is 0, every sense code is 100, and every irq_o bit is low.
- R2: The enable bit of line i is bit (i mod 32) of the register word at word address 4 + i/32. Word bits that map to no line read 0, and writes to them are ignored.
- R3: The sense code of line i occupies bits [2:0] of the word at word address 68 + i. It reads back exactly as written, including codes 001, 011 and 101, with bits [31:3] reading 0. A read of an address that maps to nothing returns 0. Read data is valid on reg_rdata_o in the cycle after the request edge.
- R4: With code 100, or with any of the unlisted codes 001, 011 and 101, an enabled line drives irq_o at the level of its input. A change on the input appears at the output on the third rising clock edge after it.
- R5: With code 000, an enabled line drives irq_o as the inverse of its input, with the same three-edge latency.
- R6: With code 110, each rise of the input produces a high pulse on irq_o exactly one cycle wide, three edges later. A fall produces nothing.
- R7: With code 010, each fall of the input produces a one-cycle high pulse three edges later. A rise produces nothing.
- R8: With code 111, each rise and each fall of the input produces a one-cycle high pulse three edges later.
- R9: A disabled line holds irq_o low whatever its input does. A write to an enable or a sense code takes effect on irq_o at the rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 for a write, 0 for a read |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| wake_i | input | N_LINES | Asynchronous wake inputs |
| irq_o | output | N_LINES | Normalised interrupt outputs |

## Verification
Each input change is due at irq_o on the third rising edge after it: two edges in the synchroniser and one in the output register. An edge pulse must be high on that edge and low again on the next one. Register writes reach irq_o one edge after the write edge, and read data is due one edge after the request. The driver records every expectation in the scoreboard with its due cycle counted from the cycle of the stimulus. The monitor compares only on falling edges whose cycle count matches, so that each output is sampled in the one cycle it is defined for.

// File: rtl/wsn_pkg.sv
package wsn_pkg;
  localparam int DATA_W        = 32;
  localparam int EN_BASE_WORD  = 4;   // byte 0x10
  localparam int CFG_BASE_WORD = 68;  // byte 0x110

  typedef enum logic [2:0] {
    SENSE_LVL_LO = 3'b000,
    SENSE_FALL   = 3'b010,
    SENSE_LVL_HI = 3'b100,
    SENSE_RISE   = 3'b110,
    SENSE_BOTH   = 3'b111
  } sense_e;
endpackage

// File: rtl/wsn_regs.sv
module wsn_regs
  import wsn_pkg::*;
#(
  parameter int N_LINES = 168,
  parameter int ADDR_W  = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [N_LINES-1:0]       en_o,
  output logic [N_LINES-1:0][2:0]  sense_o
);
  logic [N_LINES-1:0]      en_q;
  logic [N_LINES-1:0][2:0] sense_q;
  logic [DATA_W-1:0]       rd_d, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      sense_q <= {N_LINES{SENSE_LVL_HI}};
    end else if (req_i && we_i) begin
      for (int i = 0; i < N_LINES; i++) begin
        if (addr_i == ADDR_W'(EN_BASE_WORD + i / 32)) en_q[i] <= wdata_i[i % 32];
        if (addr_i == ADDR_W'(CFG_BASE_WORD + i))     sense_q[i] <= wdata_i[2:0];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (addr_i == ADDR_W'(EN_BASE_WORD + i / 32)) rd_d[i % 32] = en_q[i];
      if (addr_i == ADDR_W'(CFG_BASE_WORD + i))     rd_d[2:0]    = sense_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (req_i && !we_i)   rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign sense_o = sense_q;

  p_en_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(EN_BASE_WORD)) |=> en_q[0] == $past(wdata_i[0]));
  p_cfg_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(CFG_BASE_WORD)) |=> sense_q[0] == $past(wdata_i[2:0]));
endmodule

// File: rtl/wsn_line.sv
module wsn_line
  import wsn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wake_i,
  input  logic       en_i,
  input  logic [2:0] sense_i,
  output logic       irq_o
);
  logic s1_q, s2_q, s3_q, irq_d, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {s1_q, s2_q, s3_q} <= '0;
    else         {s1_q, s2_q, s3_q} <= {wake_i, s1_q, s2_q};
  end

  // s3_q holds the previous synchronised sample for edge detection
  always_comb begin
    case (sense_i)
      SENSE_LVL_LO: irq_d = !s2_q;
      SENSE_FALL:   irq_d = s3_q && !s2_q;
      SENSE_RISE:   irq_d = !s3_q && s2_q;
      SENSE_BOTH:   irq_d = s3_q ^ s2_q;
      default:      irq_d = s2_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_i && irq_d;
  end

  assign irq_o = irq_q;

  p_disabled_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);
  p_lvl_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sense_i == SENSE_LVL_LO) |=> irq_o == !$past(s2_q));
  p_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sense_i == SENSE_RISE && $rose(s2_q)) |=> irq_o);
  p_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sense_i == SENSE_FALL && $fell(s2_q)) |=> irq_o);
  p_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sense_i == SENSE_BOTH && !$stable(s2_q)) |=> irq_o);
endmodule

// File: rtl/wake_sense_norm.sv
module wake_sense_norm
  import wsn_pkg::*;
#(
  parameter int N_LINES = 168,
  parameter int ADDR_W  = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [N_LINES-1:0] wake_i,
  output logic [N_LINES-1:0] irq_o
);
  logic [N_LINES-1:0]      en;
  logic [N_LINES-1:0][2:0] sense;

  wsn_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (reg_req_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (en),
    .sense_o (sense)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    wsn_line u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wake_i  (wake_i[g]),
      .en_i    (en[g]),
      .sense_i (sense[g]),
      .irq_o   (irq_o[g])
    );
  end
endmodule

// File: tb/wake_sense_norm_tb_top.sv
`timescale 1ns/1ps
module wake_sense_norm_tb_top;
  localparam int N  = 40;
  localparam int AW = 9;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] wake = '0;
  logic [N-1:0] irq;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    int          due;
    bit          is_rd;
    int          line;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  wake_sense_norm #(.N_LINES(N), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .wake_i(wake), .irq_o(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare items due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] got;
        got = sb[i].is_rd ? rdata : {31'b0, irq[sb[i].line]};
        checks++;
        if (got !== sb[i].exp) begin
          fails++;
          $display("FAIL %s line %0d cyc %0d: got %h exp %h",
                   sb[i].tag, sb[i].line, cyc, got, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic push_irq(int line, bit v, int dly, string tag);
    item_t it;
    it.due = cyc + dly; it.is_rd = 0; it.line = line; it.exp = {31'b0, v}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    req = 1; we = 1; addr = AW'(a); wdata = d;
    tick(1);
    req = 0; we = 0;
  endtask

  task automatic bus_read(int a, logic [31:0] e, string tag);
    item_t it;
    req = 1; we = 0; addr = AW'(a);
    it.due = cyc + 1; it.is_rd = 1; it.line = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    tick(1);
    req = 0;
  endtask

  // set a wake input, expect level v at +3 and optional value at +4
  task automatic drive(int line, bit lvl, bit v3, bit v4, string tag);
    wake[line] = lvl;
    push_irq(line, v3, 3, tag);
    push_irq(line, v4, 4, tag);
    tick(5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cyc %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    // R1 reset state
    for (int l = 0; l < N; l++) push_irq(l, 0, 1, "R1");
    tick(1);
    bus_read(68, 32'h4, "R1");
    bus_read(4, 32'h0, "R1");
    // R3 configure codes
    bus_write(68 + 1, 32'h0);
    bus_write(68 + 2, 32'h2);
    bus_write(68 + 3, 32'h6);
    bus_write(68 + 4, 32'h7);
    bus_write(68 + 5, 32'h5);
    bus_read(68 + 5, 32'h5, "R3");
    bus_write(68 + 6, 32'hFFFF_FFF9);
    bus_read(68 + 6, 32'h1, "R3");
    bus_read(0, 32'h0, "R3");
    bus_read(200, 32'h0, "R3");
    // R9 enable takes effect next edge; R5 low input shows high
    bus_write(4, 32'h3F);
    push_irq(1, 1, 1, "R5");
    push_irq(0, 0, 1, "R4");
    tick(2);
    // R4 level high
    drive(0, 1, 1, 1, "R4");
    drive(0, 0, 0, 0, "R4");
    drive(5, 1, 1, 1, "R4");
    // R5 level low
    drive(1, 1, 0, 0, "R5");
    // R7 falling
    drive(2, 1, 0, 0, "R7");
    drive(2, 0, 1, 0, "R7");
    // R6 rising
    drive(3, 1, 1, 0, "R6");
    drive(3, 0, 0, 0, "R6");
    // R8 both
    drive(4, 1, 1, 0, "R8");
    drive(4, 0, 1, 0, "R8");
    // R9 disable lines 4 and 5
    bus_write(4, 32'h0F);
    push_irq(5, 0, 1, "R9");
    tick(2);
    drive(4, 1, 0, 0, "R9");
    bus_read(4, 32'h0F, "R2");
    // R2 second enable word, unmapped bits
    bus_write(5, 32'hFFFF_FFFF);
    bus_read(5, 32'h0000_00FF, "R2");
    drive(35, 1, 1, 1, "R2");
    push_irq(34, 0, 1, "R2");
    tick(6);
    done = 1;
    if (sb.size() != 0) begin
      fails += sb.size();
      $display("FAIL scoreboard left %0d items", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule